// File: doc/BRIEF.md
# Predicate Register File with Guarded Commit

This block keeps a bank of one-bit predicate flags and rules on whether each operation's result may become visible. Compare operations write a complementary pair of flags at once. The first destination takes the outcome of the relation and the second takes its inverse. A third flag can gate that pair write, so nested conditions can be built without branches.

While a compare is in flight, both of its destinations are marked as waiting. An operation whose flag is still waiting when it issues may run ahead. When it asks to commit, it is held until the flag resolves. Then it is either committed or discarded. An operation whose flag was already known to be false at issue should not have run. If it asks anyway, it is reported as skipped. Index 0 always reads as true, so "unconditional" is encoded as flag 0.

Top module: `pred_commit_unit`

## Requirements
- R1: After reset every flag except index 0 reads false and nothing is waiting. Flag 0 always reads true and never waits.
- R2: A compare write-back whose relation holds sets flag `wbDstJ` to 1 and flag `wbDstK` to 0, visible on the query port in the following cycle.
- R3: A compare write-back whose relation fails sets `wbDstJ` to 0 and `wbDstK` to 1.
- R4: A write-back whose guard flag `wbGuard` reads 0 leaves both destinations unchanged. Guard index 0 makes the write unconditional.
- R5: Relation code 0 is equality, 1 is inequality, 2 is signed less-than and 3 is signed greater-or-equal. Each compares `wbOpA` with `wbImm` when `wbUseImm` is 1, and with `wbOpB` otherwise.
- R6: When both destinations name the same flag, that flag takes the value meant for `wbDstJ`.
- R7: Writes aimed at index 0 are ignored.
- R8: A compare issue marks both destinations as waiting, and `qryPending` shows it. A waiting flag reports `qryExec` = 1, meaning the operation may run speculatively. The write-back for a destination clears its waiting mark.
- R9: `cmtReady` is 0 while the flag named by `cmtPred` is waiting, and no decision is produced for that cycle.
- R10: An accepted commit with a true flag gives `decKind` = 1 (commit) and `decResult` equal to the pending result. A false flag with `cmtSpec` = 1 gives 2 (discard). A false flag with `cmtSpec` = 0 gives 3 (skip). Both 2 and 3 force `decResult` to 0, and `decKind` = 0 means no decision.
- R11: A decision appears exactly one cycle after the commit request is accepted, and for that cycle only.
- R12: Operations tagged with flag 0 always commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| issValid | input | 1 | compare issued this cycle |
| issDstJ | input | 6 | issued compare, first destination |
| issDstK | input | 6 | issued compare, second destination |
| wbValid | input | 1 | compare write-back this cycle |
| wbDstJ | input | 6 | write-back first destination |
| wbDstK | input | 6 | write-back second destination |
| wbGuard | input | 6 | guard flag index (0 = none) |
| wbRel | input | 2 | relation code |
| wbUseImm | input | 1 | compare against immediate |
| wbOpA | input | 32 | first operand |
| wbOpB | input | 32 | second register operand |
| wbImm | input | 32 | immediate operand |
| qryPred | input | 6 | flag index queried at issue |
| qryExec | output | 1 | operation may execute |
| qryPending | output | 1 | queried flag still waiting |
| cmtValid | input | 1 | commit request |
| cmtPred | input | 6 | flag of the committing operation |
| cmtSpec | input | 1 | flag was unknown when the operation issued |
| cmtResult | input | 32 | pending result |
| cmtReady | output | 1 | commit accepted this cycle |
| decKind | output | 2 | decision code |
| decResult | output | 32 | released result |

## Verification
A corrupted flag bit shows up in the very next cycle on the query port as a wrong `qryExec`. It also shows on the decision code of any commit tagged with that flag, one cycle after acceptance. A stuck waiting mark shows as `cmtReady` held low indefinitely, so the scoreboard is left with an expected decision that never arrives. A wrong relation, a pair written in the wrong order or a guard that does not gate all show up as a flipped flag value. The bench reads that value back right after the write-back cycle.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_NE = 2'd1,
    REL_LT = 2'd2,
    REL_GE = 2'd3
  } predRel_e;

  typedef enum logic [1:0] {
    DEC_NONE    = 2'd0,
    DEC_COMMIT  = 2'd1,
    DEC_DISCARD = 2'd2,
    DEC_SKIP    = 2'd3
  } predDec_e;

  typedef struct packed {
    logic pairWr;   // write the complementary pair
    logic pendSet;  // mark issued destinations as waiting
    logic pendClr;  // clear waiting marks of write-back destinations
  } predStrobe_t;

endpackage

// File: rtl/pred_cmp.sv
module pred_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] imm,
  input  logic              useImm,
  input  pred_pkg::predRel_e rel,
  output logic              relTrue
);
  import pred_pkg::*;

  logic [DATA_W-1:0] rhs;
  logic isEq;
  logic isLt;

  assign rhs  = useImm ? imm : opB;
  assign isEq = (opA == rhs);
  assign isLt = ($signed(opA) < $signed(rhs));

  always_comb begin
    unique case (rel)
      REL_EQ:  relTrue = isEq;
      REL_NE:  relTrue = !isEq;
      REL_LT:  relTrue = isLt;
      default: relTrue = !isLt;
    endcase
  end
endmodule

// File: rtl/pred_dp.sv
module pred_dp #(
  parameter int NUM_PRED = 64,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pred_pkg::predStrobe_t strobe,
  input  logic [IDX_W-1:0]      issDstJ,
  input  logic [IDX_W-1:0]      issDstK,
  input  logic [IDX_W-1:0]      wbDstJ,
  input  logic [IDX_W-1:0]      wbDstK,
  input  logic [IDX_W-1:0]      wbGuard,
  input  logic [1:0]            wbRel,
  input  logic                  wbUseImm,
  input  logic [DATA_W-1:0]     wbOpA,
  input  logic [DATA_W-1:0]     wbOpB,
  input  logic [DATA_W-1:0]     wbImm,
  input  logic [IDX_W-1:0]      qryPred,
  input  logic [IDX_W-1:0]      cmtPred,
  output logic                  guardVal,
  output logic                  qryVal,
  output logic                  qryPend,
  output logic                  cmtVal,
  output logic                  cmtPend
);
  import pred_pkg::*;

  logic [NUM_PRED-1:1] valQ;
  logic [NUM_PRED-1:1] pendQ;
  logic [NUM_PRED-1:0] predVal;
  logic [NUM_PRED-1:0] pendVec;
  logic                relTrue;

  // Index 0 is a constant true flag that never waits.
  assign predVal = {valQ, 1'b1};
  assign pendVec = {pendQ, 1'b0};

  pred_cmp #(.DATA_W(DATA_W)) uCmp (
    .opA    (wbOpA),
    .opB    (wbOpB),
    .imm    (wbImm),
    .useImm (wbUseImm),
    .rel    (predRel_e'(wbRel)),
    .relTrue(relTrue)
  );

  assign guardVal = predVal[wbGuard];
  assign qryVal   = predVal[qryPred];
  assign qryPend  = pendVec[qryPred];
  assign cmtVal   = predVal[cmtPred];
  assign cmtPend  = pendVec[cmtPred];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valQ  <= '0;
      pendQ <= '0;
    end else begin
      for (int i = 1; i < NUM_PRED; i++) begin
        if (strobe.pairWr) begin
          // The second destination is written first so the first one wins on overlap.
          if (IDX_W'(i) == wbDstK) valQ[i] <= !relTrue;
          if (IDX_W'(i) == wbDstJ) valQ[i] <= relTrue;
        end
        if (strobe.pendClr && (IDX_W'(i) == wbDstJ || IDX_W'(i) == wbDstK))
          pendQ[i] <= 1'b0;
        if (strobe.pendSet && (IDX_W'(i) == issDstJ || IDX_W'(i) == issDstK))
          pendQ[i] <= 1'b1;
      end
    end
  end

  AST_PAIR_FIRST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pairWr && wbDstJ != '0) |=> predVal[$past(wbDstJ)] == $past(relTrue)); // R6

  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pairWr && wbDstK != '0 && wbDstK != wbDstJ)
      |=> predVal[$past(wbDstK)] == !$past(relTrue)); // R3

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pairWr |=> $stable(predVal)); // R4

  AST_WB_CLEARS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pendClr && !strobe.pendSet) |=> !pendVec[$past(wbDstJ)]); // R8

  AST_ISSUE_SETS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pendSet && issDstJ != '0) |=> pendVec[$past(issDstJ)]); // R8
endmodule

// File: rtl/pred_ctrl.sv
module pred_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issValid,
  input  logic                  wbValid,
  input  logic                  guardVal,
  input  logic                  cmtValid,
  input  logic                  cmtSpec,
  input  logic [DATA_W-1:0]     cmtResult,
  input  logic                  cmtVal,
  input  logic                  cmtPend,
  output pred_pkg::predStrobe_t strobe,
  output logic                  cmtReady,
  output pred_pkg::predDec_e    decKind,
  output logic [DATA_W-1:0]     decResult
);
  import pred_pkg::*;

  logic     accept;
  predDec_e nextKind;

  always_comb begin
    strobe         = '0;
    strobe.pairWr  = wbValid && guardVal;
    strobe.pendClr = wbValid;
    strobe.pendSet = issValid;
  end

  assign cmtReady = !cmtPend;
  assign accept   = cmtValid && !cmtPend;

  always_comb begin
    if (!accept)     nextKind = DEC_NONE;
    else if (cmtVal) nextKind = DEC_COMMIT;
    else if (cmtSpec) nextKind = DEC_DISCARD;
    else             nextKind = DEC_SKIP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decKind   <= DEC_NONE;
      decResult <= '0;
    end else begin
      decKind   <= nextKind;
      decResult <= (nextKind == DEC_COMMIT) ? cmtResult : '0;
    end
  end

  AST_STALL_NO_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && cmtPend) |=> decKind == DEC_NONE); // R9

  AST_DECISION_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && !cmtPend) |=> decKind != DEC_NONE); // R11

  AST_FALSE_NEVER_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && !cmtVal) |=> decKind != DEC_COMMIT); // R10
endmodule

// File: rtl/pred_commit_unit.sv
module pred_commit_unit #(
  parameter int NUM_PRED = 64,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issValid,
  input  logic [IDX_W-1:0]  issDstJ,
  input  logic [IDX_W-1:0]  issDstK,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbDstJ,
  input  logic [IDX_W-1:0]  wbDstK,
  input  logic [IDX_W-1:0]  wbGuard,
  input  logic [1:0]        wbRel,
  input  logic              wbUseImm,
  input  logic [DATA_W-1:0] wbOpA,
  input  logic [DATA_W-1:0] wbOpB,
  input  logic [DATA_W-1:0] wbImm,
  input  logic [IDX_W-1:0]  qryPred,
  output logic              qryExec,
  output logic              qryPending,
  input  logic              cmtValid,
  input  logic [IDX_W-1:0]  cmtPred,
  input  logic              cmtSpec,
  input  logic [DATA_W-1:0] cmtResult,
  output logic              cmtReady,
  output logic [1:0]        decKind,
  output logic [DATA_W-1:0] decResult
);
  import pred_pkg::*;

  predStrobe_t strobe;
  predDec_e    decKindE;
  logic        guardVal;
  logic        qryVal;
  logic        cmtVal;
  logic        cmtPend;

  pred_dp #(.NUM_PRED(NUM_PRED), .DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .issDstJ (issDstJ),
    .issDstK (issDstK),
    .wbDstJ  (wbDstJ),
    .wbDstK  (wbDstK),
    .wbGuard (wbGuard),
    .wbRel   (wbRel),
    .wbUseImm(wbUseImm),
    .wbOpA   (wbOpA),
    .wbOpB   (wbOpB),
    .wbImm   (wbImm),
    .qryPred (qryPred),
    .cmtPred (cmtPred),
    .guardVal(guardVal),
    .qryVal  (qryVal),
    .qryPend (qryPending),
    .cmtVal  (cmtVal),
    .cmtPend (cmtPend)
  );

  pred_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .issValid (issValid),
    .wbValid  (wbValid),
    .guardVal (guardVal),
    .cmtValid (cmtValid),
    .cmtSpec  (cmtSpec),
    .cmtResult(cmtResult),
    .cmtVal   (cmtVal),
    .cmtPend  (cmtPend),
    .strobe   (strobe),
    .cmtReady (cmtReady),
    .decKind  (decKindE),
    .decResult(decResult)
  );

  // A waiting flag lets the operation run speculatively.
  assign qryExec = qryVal || qryPending;
  assign decKind = decKindE;

  AST_UNCOND_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && cmtPred == '0) |=> decKind == 2'd1); // R12
endmodule

// File: tb/sim_pred_commit_unit.sv
module sim_pred_commit_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issValid = 0;
  logic [5:0]  issDstJ = 0, issDstK = 0;
  logic        wbValid = 0;
  logic [5:0]  wbDstJ = 0, wbDstK = 0, wbGuard = 0;
  logic [1:0]  wbRel = 0;
  logic        wbUseImm = 0;
  logic [31:0] wbOpA = 0, wbOpB = 0, wbImm = 0;
  logic [5:0]  qryPred = 0;
  logic        qryExec, qryPending;
  logic        cmtValid = 0;
  logic [5:0]  cmtPred = 0;
  logic        cmtSpec = 0;
  logic [31:0] cmtResult = 0;
  logic        cmtReady;
  logic [1:0]  decKind;
  logic [31:0] decResult;

  int checks = 0;
  int errors = 0;
  logic [33:0] sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_commit_unit u0 (.*);

  task automatic check(input logic ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every decision is compared against the queue head.
  always @(negedge clk) begin
    if (rstN && decKind != 2'd0) begin
      if (sbQ.size() == 0) check(1'b0, "R11 unexpected decision", {decKind, decResult}, 34'h0);
      else begin
        logic [33:0] e;
        e = sbQ.pop_front();
        check({decKind, decResult} == e, "R10 decision", {decKind, decResult}, e);
      end
    end
  end

  task automatic qry(input logic [5:0] idx, input logic expExec, input logic expPend, input string tag);
    @(negedge clk);
    qryPred = idx;
    #1;
    check(qryExec == expExec && qryPending == expPend, tag, {qryExec, qryPending}, {expExec, expPend});
  endtask

  task automatic wb(input logic [5:0] j, input logic [5:0] k, input logic [5:0] g, input logic [1:0] rel,
                    input logic useImm, input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm);
    @(negedge clk);
    wbValid = 1; wbDstJ = j; wbDstK = k; wbGuard = g; wbRel = rel;
    wbUseImm = useImm; wbOpA = a; wbOpB = b; wbImm = imm;
    @(negedge clk);
    wbValid = 0;
  endtask

  task automatic cmt(input logic [5:0] idx, input logic spec, input logic [31:0] res, input logic [1:0] expKind);
    @(negedge clk);
    cmtValid = 1; cmtPred = idx; cmtSpec = spec; cmtResult = res;
    #1;
    check(cmtReady == 1'b1, "R9 ready on settled flag", {33'h0, cmtReady}, 34'h1);
    sbQ.push_back({expKind, (expKind == 2'd1) ? res : 32'h0});
    @(negedge clk);
    cmtValid = 0;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 34'h0, 34'h1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    qry(6'd0, 1, 0, "R1 flag0 true");
    qry(6'd7, 0, 0, "R1 flag7 false");
    qry(6'd63, 0, 0, "R1 flag63 false");
    // R2/R5 equality against immediate, true
    wb(6'd1, 6'd2, 6'd0, 2'd0, 1, 32'd5, 32'd9, 32'd5);
    qry(6'd1, 1, 0, "R2 first dest set");
    qry(6'd2, 0, 0, "R2 second dest cleared");
    // R3/R5 inequality between registers, false
    wb(6'd3, 6'd4, 6'd0, 2'd1, 0, 32'd3, 32'd3, 32'd0);
    qry(6'd3, 0, 0, "R3 first dest cleared");
    qry(6'd4, 1, 0, "R3 second dest set");
    // R5 signed less-than true, greater-or-equal false
    wb(6'd10, 6'd11, 6'd0, 2'd2, 0, 32'hFFFF_FFFF, 32'd1, 32'd0);
    qry(6'd10, 1, 0, "R5 signed lt");
    wb(6'd12, 6'd13, 6'd0, 2'd3, 1, 32'hFFFF_FFFF, 32'd0, 32'd1);
    qry(6'd12, 0, 0, "R5 signed ge first");
    qry(6'd13, 1, 0, "R5 signed ge second");
    // R4 guard false holds, guard true writes
    wb(6'd1, 6'd2, 6'd2, 2'd1, 1, 32'd7, 32'd0, 32'd7);
    qry(6'd1, 1, 0, "R4 guarded hold first");
    qry(6'd2, 0, 0, "R4 guarded hold second");
    wb(6'd20, 6'd21, 6'd1, 2'd0, 1, 32'd4, 32'd0, 32'd4);
    qry(6'd20, 1, 0, "R4 guard true first");
    qry(6'd21, 0, 0, "R4 guard true second");
    // R6 same destination: first destination wins
    wb(6'd30, 6'd30, 6'd0, 2'd0, 1, 32'd1, 32'd0, 32'd1);
    qry(6'd30, 1, 0, "R6 overlap true");
    wb(6'd30, 6'd30, 6'd0, 2'd0, 1, 32'd1, 32'd0, 32'd2);
    qry(6'd30, 0, 0, "R6 overlap false");
    // R7 writes to flag 0 ignored
    wb(6'd0, 6'd40, 6'd0, 2'd0, 1, 32'd1, 32'd0, 32'd2);
    qry(6'd0, 1, 0, "R7 flag0 kept");
    qry(6'd40, 1, 0, "R7 partner written");
    // R8 issue marks waiting
    @(negedge clk);
    issValid = 1; issDstJ = 6'd5; issDstK = 6'd6;
    @(negedge clk);
    issValid = 0;
    qry(6'd5, 1, 1, "R8 waiting speculative exec");
    qry(6'd6, 1, 1, "R8 waiting second");
    // R9 stall while waiting
    @(negedge clk);
    cmtValid = 1; cmtPred = 6'd5; cmtSpec = 1; cmtResult = 32'hA5A5_0001;
    #1;
    check(cmtReady == 1'b0, "R9 stalled", {33'h0, cmtReady}, 34'h0);
    @(negedge clk);
    #1;
    check(cmtReady == 1'b0, "R9 still stalled", {33'h0, cmtReady}, 34'h0);
    wbValid = 1; wbDstJ = 6'd5; wbDstK = 6'd6; wbGuard = 0; wbRel = 2'd0;
    wbUseImm = 1; wbOpA = 32'd8; wbImm = 32'd8;
    @(negedge clk);
    wbValid = 0;
    #1;
    check(cmtReady == 1'b1, "R9 released", {33'h0, cmtReady}, 34'h1);
    sbQ.push_back({2'd1, 32'hA5A5_0001});
    @(negedge clk);
    cmtValid = 0;
    qry(6'd5, 1, 0, "R8 waiting cleared");
    // R10/R12 decisions
    cmt(6'd1, 0, 32'h1111_2222, 2'd1);
    cmt(6'd2, 1, 32'h3333_4444, 2'd2);
    cmt(6'd2, 0, 32'h5555_6666, 2'd3);
    cmt(6'd6, 1, 32'h7777_8888, 2'd2);
    cmt(6'd0, 0, 32'h9999_AAAA, 2'd1);
    repeat (3) @(negedge clk);
    check(sbQ.size() == 0, "R11 all decisions arrived", 34'(sbQ.size()), 34'h0);
    report();
  end
endmodule